// File: doc/BRIEF.md
# Register-Register Integer Execution Unit

This block computes the write-back value for the integer register-register operations of a small register machine. Each cycle it takes an operation code, a 16-bit variant field, a width-select bit and two 64-bit operands: the current destination value and the source value. One cycle later it presents the value to be written back to the destination, together with a flag that marks an encoding it does not support.

The variant field separates operations that share one operation code. Plain move and sign-extending move are the only pair that use this. Every other supported code requires the variant field to be zero. In 32-bit mode only the low halves of the operands take part, arithmetic wraps at 32 bits, and the upper half of the result is always cleared. Division, modulo and byte-swap codes are handled elsewhere. This unit reports them as unsupported.

Top module: `alu_exec`

## Requirements
- R1: The result and flag are registered, so inputs sampled at one rising clock edge appear on `res_o`/`illegal_o` after that edge. An active-low asynchronous reset clears both outputs to zero.
- R2: Code 0x0 adds and code 0x1 subtracts (dst minus src). Both wrap silently at the selected width.
- R3: Code 0x2 returns the low 64 bits (or low 32 bits in 32-bit mode) of dst times src.
- R4: Codes 0x4, 0x5 and 0xa return the bitwise OR, AND and XOR of dst and src.
- R5: Codes 0x6 (left) and 0x7 (logical right) shift dst with zero fill. The amount is src ANDed with 63 in 64-bit mode or with 31 in 32-bit mode.
- R6: Code 0xc shifts dst right arithmetically by the same masked amount. It replicates bit 63, or bit 31 in 32-bit mode.
- R7: Code 0x8 ignores src and returns the two's-complement negation of dst at the selected width.
- R8: Code 0xb with variant 0 copies src. In 32-bit mode it copies only the low 32 bits of src.
- R9: Code 0xb with variant 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of src. Variant 32 is unsupported in 32-bit mode.
- R10: In 32-bit mode, bits 63:32 of every supported result are zero.
- R11: The following encodings are unsupported: codes 0x3, 0x9, 0xd, 0xe and 0xf; a nonzero variant on any code other than 0xb; and code 0xb with a variant outside {0, 8, 16, 32}. For these, `illegal_o` is 1 and `res_o` equals the dst operand unchanged. For supported encodings `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| off_i | input | 16 | Variant field |
| is64_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| dst_i | input | 64 | Current destination operand |
| src_i | input | 64 | Source operand |
| res_o | output | 64 | Value to write back to the destination |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The bench uses shift amounts above the mask. A design that used the raw source would return zero there instead of a small shifted value. In 32-bit mode it places nonzero bits in the upper operand halves, which catches a unit that leaks them into the result or takes the sign from bit 63 during an arithmetic shift. It checks sign-extending moves with the sign bit set and clear, and the variant-32 move in 32-bit mode. It also feeds division codes and stray variant values, which a loose decoder would execute as add or move instead of flagging them and passing the destination through.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HLEN = XLEN / 2;
  localparam int unsigned OPW  = 4;
  localparam int unsigned OFFW = 16;
  localparam int unsigned SHW  = $clog2(XLEN);

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_ARSH = 4'hc
  } opcode_e;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_MUL, K_OR, K_AND, K_XOR, K_LSH, K_RSH,
    K_ARSH, K_NEG, K_MOV, K_SX8, K_SX16, K_SX32, K_NONE
  } kind_e;

  typedef enum logic [1:0] { G_ARITH, G_SHIFT, G_MOVE, G_LOGIC } group_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [OFFW-1:0] off_i,
  input  logic            is64_i,
  output kind_e           kind_o,
  output group_e          group_o,
  output logic            legal_o
);
  logic off_zero;
  assign off_zero = (off_i == '0);

  always_comb begin
    kind_o = K_NONE;
    unique case (op_i)
      OP_ADD:  if (off_zero) kind_o = K_ADD;
      OP_SUB:  if (off_zero) kind_o = K_SUB;
      OP_MUL:  if (off_zero) kind_o = K_MUL;
      OP_OR:   if (off_zero) kind_o = K_OR;
      OP_AND:  if (off_zero) kind_o = K_AND;
      OP_XOR:  if (off_zero) kind_o = K_XOR;
      OP_LSH:  if (off_zero) kind_o = K_LSH;
      OP_RSH:  if (off_zero) kind_o = K_RSH;
      OP_ARSH: if (off_zero) kind_o = K_ARSH;
      OP_NEG:  if (off_zero) kind_o = K_NEG;
      OP_MOV: begin
        case (off_i)
          16'd0:  kind_o = K_MOV;
          16'd8:  kind_o = K_SX8;
          16'd16: kind_o = K_SX16;
          16'd32: if (is64_i) kind_o = K_SX32; // 32-bit source into 32-bit dst is not a variant
          default: kind_o = K_NONE;
        endcase
      end
      default: kind_o = K_NONE;
    endcase
  end

  always_comb begin
    unique case (kind_o)
      K_ADD, K_SUB, K_MUL, K_NEG:          group_o = G_ARITH;
      K_LSH, K_RSH, K_ARSH:                group_o = G_SHIFT;
      K_MOV, K_SX8, K_SX16, K_SX32:        group_o = G_MOVE;
      default:                             group_o = G_LOGIC;
    endcase
  end

  assign legal_o = (kind_o != K_NONE);
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  kind_e          kind_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   arith_o,
  output logic [W-1:0]   logic_o
);
  logic [W-1:0] sum, diff, prod, neg;
  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign prod = a_i * b_i;
  assign neg  = '0 - a_i;

  always_comb begin
    unique case (kind_i)
      K_SUB:   arith_o = diff;
      K_MUL:   arith_o = prod;
      K_NEG:   arith_o = neg;
      default: arith_o = sum;
    endcase
  end

  always_comb begin
    unique case (kind_i)
      K_AND:   logic_o = a_i & b_i;
      K_XOR:   logic_o = a_i ^ b_i;
      default: logic_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  kind_e        kind_i,
  input  logic         is64_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] shift_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned SW = $clog2(W);
  localparam logic [SW-1:0] MASK_F = SW'(W - 1);
  localparam logic [SW-1:0] MASK_H = SW'(H - 1);

  logic [SW-1:0] amt;
  logic [W-1:0]  sra_full;
  logic [H-1:0]  sra_half;

  assign amt      = b_i[SW-1:0] & (is64_i ? MASK_F : MASK_H);
  assign sra_full = W'($signed(a_i) >>> amt);
  assign sra_half = H'($signed(a_i[H-1:0]) >>> amt);

  always_comb begin
    unique case (kind_i)
      K_LSH:   shift_o = a_i << amt;
      K_ARSH:  shift_o = is64_i ? sra_full : {{H{1'b0}}, sra_half};
      default: shift_o = a_i >> amt; // operand already zero-extended in 32-bit mode
    endcase
  end
endmodule

// File: rtl/alu_move.sv
module alu_move
  import alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  kind_e        kind_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] move_o
);
  localparam int unsigned NSX = 3;
  localparam int unsigned SXW [NSX] = '{8, 16, 32};

  logic [W-1:0] sx [NSX];

  for (genvar g = 0; g < NSX; g++) begin : g_sx
    assign sx[g] = {{(W - SXW[g]){b_i[SXW[g]-1]}}, b_i[SXW[g]-1:0]};
  end

  always_comb begin
    unique case (kind_i)
      K_SX8:   move_o = sx[0];
      K_SX16:  move_o = sx[1];
      K_SX32:  move_o = sx[2];
      default: move_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OPW-1:0]  op_i,
  input  logic [OFFW-1:0] off_i,
  input  logic            is64_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] res_o,
  output logic            illegal_o
);
  kind_e        kind;
  group_e       group;
  logic         legal;
  logic [XLEN-1:0] a, b, r_arith, r_logic, r_shift, r_move, r_sel, r_nxt;

  alu_decode u_dec (
    .op_i(op_i), .off_i(off_i), .is64_i(is64_i),
    .kind_o(kind), .group_o(group), .legal_o(legal)
  );

  // 32-bit mode works on zero-extended low halves
  assign a = is64_i ? dst_i : {{HLEN{1'b0}}, dst_i[HLEN-1:0]};
  assign b = is64_i ? src_i : {{HLEN{1'b0}}, src_i[HLEN-1:0]};

  alu_arith #(.W(XLEN)) u_arith (
    .kind_i(kind), .a_i(a), .b_i(b), .arith_o(r_arith), .logic_o(r_logic)
  );

  alu_shift #(.W(XLEN)) u_shift (
    .kind_i(kind), .is64_i(is64_i), .a_i(a), .b_i(b), .shift_o(r_shift)
  );

  alu_move #(.W(XLEN)) u_move (
    .kind_i(kind), .b_i(b), .move_o(r_move)
  );

  always_comb begin
    unique case (group)
      G_ARITH: r_sel = r_arith;
      G_SHIFT: r_sel = r_shift;
      G_MOVE:  r_sel = r_move;
      default: r_sel = r_logic;
    endcase
  end

  always_comb begin
    if (!legal)       r_nxt = dst_i;
    else if (is64_i)  r_nxt = r_sel;
    else              r_nxt = {{HLEN{1'b0}}, r_sel[HLEN-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= r_nxt;
      illegal_o <= ~legal;
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OPW-1:0]  op_i,
  input logic [OFFW-1:0] off_i,
  input logic            is64_i,
  input logic [XLEN-1:0] dst_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] res_o,
  input logic            illegal_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  // R11
  illegal_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && illegal_o) |-> res_o == $past(dst_i));

  // R11
  div_code_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && ($past(op_i) == 4'h3 || $past(op_i) == 4'h9)) |-> illegal_o);

  // R10
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !illegal_o && !$past(is64_i)) |-> res_o[XLEN-1:HLEN] == '0);

  // R7
  neg64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(op_i) == 4'h8 && $past(off_i) == '0 && $past(is64_i))
      |-> res_o == ('0 - $past(dst_i)));

  // R2
  add64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(op_i) == 4'h0 && $past(off_i) == '0 && $past(is64_i))
      |-> res_o == ($past(dst_i) + $past(src_i)));

  // R6
  arsh_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(op_i) == 4'hc && $past(off_i) == '0 && $past(is64_i))
      |-> res_o[XLEN-1] == $past(dst_i[XLEN-1]));

  // R8
  mov64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(op_i) == 4'hb && $past(off_i) == '0 && $past(is64_i))
      |-> res_o == $past(src_i));
endmodule

bind alu_exec alu_exec_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .off_i(off_i), .is64_i(is64_i),
  .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .illegal_o(illegal_o)
);

// File: tb/sim_alu_exec.sv
module sim_alu_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] off_i = '0;
  logic        is64_i = 1'b1;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [63:0] res_o;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alu_exec u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .off_i(off_i), .is64_i(is64_i),
    .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, logic [63:0] exp_r, logic exp_i);
    total++;
    if (res_o !== exp_r || illegal_o !== exp_i) begin
      bad++;
      $display("FAIL %s: res=%h ill=%b expected res=%h ill=%b", req, res_o, illegal_o, exp_r, exp_i);
    end
  endtask

  // drive at negedge, registered result visible at next negedge
  task automatic run(string req, logic [3:0] op, logic [15:0] off, logic w64,
                     logic [63:0] d, logic [63:0] s, logic [63:0] exp_r, logic exp_i);
    @(negedge clk_i);
    op_i = op; off_i = off; is64_i = w64; dst_i = d; src_i = s;
    @(negedge clk_i);
    check(req, exp_r, exp_i);
  endtask

  task automatic t_reset();
    #1; check("R1 async reset", 64'h0, 1'b0);
    @(negedge clk_i); check("R1 held in reset", 64'h0, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic t_add_sub();
    run("R2 add64 wrap", 4'h0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1, 0);
    run("R2 add32 wrap", 4'h0, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0, 0);
    run("R2 sub64 under", 4'h1, 0, 1, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R2 sub32 under", 4'h1, 0, 0, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF, 0);
  endtask

  task automatic t_mul();
    run("R3 mul64", 4'h2, 0, 1, 64'h1_0000_0000, 64'h1_0000_0001, 64'h0000_0001_0000_0000, 0);
    run("R3 mul32", 4'h2, 0, 0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 64'h1, 0);
  endtask

  task automatic t_logic();
    run("R4 or", 4'h4, 0, 1, 64'hF0, 64'h0F, 64'hFF, 0);
    run("R4 and", 4'h5, 0, 1, 64'hF0F0_0000_0000_F0F0, 64'hFF00_0000_0000_FF00, 64'hF000_0000_0000_F000, 0);
    run("R4 xor32", 4'ha, 0, 0, 64'hFFFF_FFFF_0000_FFFF, 64'h1234_5678_FFFF_0000, 64'h0000_0000_FFFF_FFFF, 0);
  endtask

  task automatic t_shift();
    run("R5 lsh64 masked", 4'h6, 0, 1, 64'h1, 64'd65, 64'h2, 0);
    run("R5 lsh32 masked", 4'h6, 0, 0, 64'h8000_0001, 64'd33, 64'h2, 0);
    run("R5 rsh64", 4'h7, 0, 1, 64'h8000_0000_0000_0000, 64'd63, 64'h1, 0);
    run("R5 rsh32 masked", 4'h7, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd63, 64'h1, 0);
  endtask

  task automatic t_arsh();
    run("R6 arsh64 neg", 4'hc, 0, 1, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 0);
    run("R6 arsh64 pos", 4'hc, 0, 1, 64'h7000_0000_0000_0000, 64'd68, 64'h0700_0000_0000_0000, 0);
    run("R6 arsh32 bit31", 4'hc, 0, 0, 64'h0000_0000_8000_0000, 64'd4, 64'h0000_0000_F800_0000, 0);
    run("R6 arsh32 ignores hi", 4'hc, 0, 0, 64'hFFFF_FFFF_7000_0000, 64'd4, 64'h0000_0000_0700_0000, 0);
  endtask

  task automatic t_neg();
    run("R7 neg64", 4'h8, 0, 1, 64'h1, 64'hDEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R7 neg64 min", 4'h8, 0, 1, 64'h8000_0000_0000_0000, 64'h5, 64'h8000_0000_0000_0000, 0);
    run("R7 neg32", 4'h8, 0, 0, 64'h1, 64'h7, 64'h0000_0000_FFFF_FFFF, 0);
  endtask

  task automatic t_mov();
    run("R8 mov64", 4'hb, 0, 1, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 0);
    run("R8 R10 mov32", 4'hb, 0, 0, 64'hFFFF, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_9ABC_DEF0, 0);
  endtask

  task automatic t_movsx();
    run("R9 sx8 neg", 4'hb, 16'd8, 1, 64'h0, 64'h80, 64'hFFFF_FFFF_FFFF_FF80, 0);
    run("R9 sx16 pos", 4'hb, 16'd16, 1, 64'h0, 64'h1234_7FFF, 64'h7FFF, 0);
    run("R9 sx32 neg", 4'hb, 16'd32, 1, 64'h0, 64'h5555_5555_8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
    run("R9 R10 sx8 in 32-bit", 4'hb, 16'd8, 0, 64'h0, 64'hFE, 64'h0000_0000_FFFF_FFFE, 0);
    run("R9 sx32 in 32-bit illegal", 4'hb, 16'd32, 0, 64'hCAFE, 64'h8000_0000, 64'hCAFE, 1);
  endtask

  task automatic t_illegal();
    run("R11 div code", 4'h3, 0, 1, 64'h1111_2222_3333_4444, 64'h2, 64'h1111_2222_3333_4444, 1);
    run("R11 mod code", 4'h9, 0, 0, 64'hFFFF_0000_FFFF_0000, 64'h3, 64'hFFFF_0000_FFFF_0000, 1);
    run("R11 swap code", 4'hd, 0, 1, 64'h42, 64'h1, 64'h42, 1);
    run("R11 add nonzero variant", 4'h0, 16'd1, 1, 64'h10, 64'h1, 64'h10, 1);
    run("R11 mov bad variant", 4'hb, 16'd4, 1, 64'h77, 64'hFF, 64'h77, 1);
    run("R11 legal after illegal", 4'h0, 0, 1, 64'h10, 64'h1, 64'h11, 0);
  endtask

  initial begin
    t_reset();
    t_add_sub();
    t_mul();
    t_logic();
    t_shift();
    t_arsh();
    t_neg();
    t_mov();
    t_movsx();
    t_illegal();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule